// File: doc/BRIEF.md
# Nibble Link Command Bridge

This block joins a narrow host link to the wide command port of a processing array. On the way in, the host hands over one 4-bit nibble per write strobe, naming the slot it fills with a 3-bit select. Eight nibbles make a 32-bit half-word. Two half-words make one 56-bit command, which is offered to the array on a valid/ready port. On the way out, the bridge takes one 56-bit response from the array and holds it. It shows the response to the host as two 32-bit halves. The same 3-bit select picks which nibble of the current half appears on the 4-bit output, and a read strobe moves on to the next nibble.

The host has to fill and drain the nibble slots in ascending order. Any strobe whose select is not the slot the bridge expects next has no effect. The bridge holds only one command at a time. While a finished command is still waiting for the array, it refuses further host writes and raises a pending flag. A reset drops any half-built word or half-read response, so the next nibble the host writes is taken as slot 0 of the first half.

Top module: `nibble_link_bridge`

## Requirements
- R1: After reset, cmdValid, hostCmdPending and hostRspAvail are 0, rspReady is 1 and hostNibbleOut is 0.
- R2: A write strobe is accepted only when hostSel equals the next expected slot (0 after a completed half, then 1, 2, ... 7). An accepted nibble at slot i fills bits 4i+3:4i of the current half. A strobe at any other slot changes nothing.
- R3: The first half carries command bits 55:24. Bits 23:0 of the second half carry command bits 23:0, and bits 31:24 of the second half are ignored.
- R4: cmdValid rises in the cycle after the clock edge that accepts slot 7 of the second half. It then stays high with cmdData unchanged until a cycle with cmdReady high.
- R5: While a command waits (hostCmdPending high, which equals cmdValid), every write strobe is ignored. The waiting command is not altered.
- R6: rspReady is high whenever no response is held. A response is captured on an edge where rspValid and rspReady are both high, and hostRspAvail then goes high.
- R7: While a response is held, hostNibbleOut equals nibble hostSel (bits 4*hostSel+3:4*hostSel) of the current outbound half. The first half is response bits 55:24. The second half is response bits 23:0 with 8 zero bits above them. With no response held, hostNibbleOut is 0.
- R8: A read strobe advances only when hostSel equals the next expected slot. After slot 7 of the first half the second half is presented. After slot 7 of the second half the response is released and rspReady returns to 1.
- R9: A reset in the middle of a transfer discards partial state. The next command written from slot 0 is assembled exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostNibbleIn | input | 4 | Nibble written by the host |
| hostSel | input | 3 | Slot select for both writes and readback |
| hostWrStb | input | 1 | Write strobe for hostNibbleIn |
| hostRdStb | input | 1 | Read strobe that consumes the shown nibble |
| hostNibbleOut | output | 4 | Selected nibble of the outbound half |
| hostCmdPending | output | 1 | A finished command waits for the array |
| hostRspAvail | output | 1 | A response is held for readback |
| cmdData | output | 56 | Assembled command |
| cmdValid | output | 1 | Command valid |
| cmdReady | input | 1 | Array accepts the command |
| rspData | input | 56 | Response from the array |
| rspValid | input | 1 | Response valid |
| rspReady | output | 1 | Bridge can take a response |

## Verification
The assertions check on every cycle the rules that can be seen at the ports. A waiting command must stay stable until the array accepts it. cmdValid may rise only after a slot-7 write. A handshaken response must become available. The readback nibble must stay steady when the host neither moves the select nor strobes, and must be zero when nothing is held. A response may be released only after a slot-7 read.

Other behaviour needs the bench's scenarios and its cycle-by-cycle reference model. That includes the bit placement of the two halves, dropping the upper byte of the second half, ignoring out-of-order and pending-time writes, switching from the first outbound half to the second, and clearing half-built state on a mid-transfer reset.

// File: rtl/nlb_pkg.sv
package nlb_pkg;
  parameter int NIB_W   = 4;
  parameter int WORD_W  = 32;
  parameter int CMD_W   = 56;
  localparam int NIB_CNT = WORD_W / NIB_W;
  localparam int SEL_W   = $clog2(NIB_CNT);
  localparam int LO_W    = CMD_W - WORD_W;

  // strobes and levels from the control to the datapath
  typedef struct packed {
    logic [NIB_CNT-1:0] nibWrEn;
    logic               capHi;
    logic               capCmd;
    logic               capRsp;
    logic               outHalf;
    logic               outHeld;
  } ctlStrobes_t;
endpackage

// File: rtl/nlb_ctrl.sv
module nlb_ctrl
  import nlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] hostSel,
  input  logic             hostWrStb,
  input  logic             hostRdStb,
  input  logic             cmdReady,
  input  logic             rspValid,
  output logic             cmdPend,
  output logic             rspHeld,
  output ctlStrobes_t      ctl
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NIB_CNT - 1);

  logic [SEL_W-1:0] wrIdx;
  logic [SEL_W-1:0] rdIdx;
  logic             wrHalf;
  logic             rdHalf;
  logic             wrAcc;
  logic             rdAcc;
  logic             wrLast;
  logic             rdLast;

  always_comb begin
    wrAcc  = hostWrStb && !cmdPend && (hostSel == wrIdx);
    wrLast = wrAcc && (wrIdx == LAST);
    rdAcc  = hostRdStb && rspHeld && (hostSel == rdIdx);
    rdLast = rdAcc && (rdIdx == LAST);
    ctl.nibWrEn = wrAcc ? (NIB_CNT'(1) << wrIdx) : '0;
    ctl.capHi   = wrLast && !wrHalf;
    ctl.capCmd  = wrLast && wrHalf;
    ctl.capRsp  = rspValid && !rspHeld;
    ctl.outHalf = rdHalf;
    ctl.outHeld = rspHeld;
  end

  // inbound sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx   <= '0;
      wrHalf  <= 1'b0;
      cmdPend <= 1'b0;
    end else if (cmdPend) begin
      if (cmdReady) cmdPend <= 1'b0;
    end else if (wrAcc) begin
      wrIdx <= wrIdx + 1'b1;
      if (wrLast) begin
        wrHalf <= !wrHalf;
        if (wrHalf) cmdPend <= 1'b1;
      end
    end
  end

  // outbound sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx   <= '0;
      rdHalf  <= 1'b0;
      rspHeld <= 1'b0;
    end else if (!rspHeld) begin
      if (rspValid) begin
        rspHeld <= 1'b1;
        rdIdx   <= '0;
        rdHalf  <= 1'b0;
      end
    end else if (rdAcc) begin
      rdIdx <= rdIdx + 1'b1;
      if (rdLast) begin
        if (rdHalf) rspHeld <= 1'b0;
        rdHalf <= !rdHalf;
      end
    end
  end
endmodule

// File: rtl/nlb_datapath.sv
module nlb_datapath
  import nlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [NIB_W-1:0] hostNibbleIn,
  input  logic [SEL_W-1:0] hostSel,
  input  logic [CMD_W-1:0] rspData,
  output logic [CMD_W-1:0] cmdData,
  output logic [NIB_W-1:0] hostNibbleOut
);
  logic [NIB_W-1:0]  nibReg [NIB_CNT-1];
  logic [WORD_W-1:0] hiReg;
  logic [WORD_W-1:0] wordNow;
  logic [CMD_W-1:0]  rspReg;
  logic [WORD_W-1:0] outWord;
  logic [NIB_W-1:0]  muxOut;

  // separately enabled nibble registers; the last slot comes straight from the pins
  for (genvar n = 0; n < NIB_CNT - 1; n++) begin : g_nib
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) nibReg[n] <= '0;
      else if (ctl.nibWrEn[n]) nibReg[n] <= hostNibbleIn;
    end
    assign wordNow[n*NIB_W +: NIB_W] = nibReg[n];
  end
  assign wordNow[WORD_W-1 -: NIB_W] = hostNibbleIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg   <= '0;
      cmdData <= '0;
      rspReg  <= '0;
    end else begin
      if (ctl.capHi)  hiReg   <= wordNow;
      if (ctl.capCmd) cmdData <= {hiReg, wordNow[LO_W-1:0]};
      if (ctl.capRsp) rspReg  <= rspData;
    end
  end

  assign outWord = ctl.outHalf ? {{(WORD_W-LO_W){1'b0}}, rspReg[LO_W-1:0]}
                               : rspReg[CMD_W-1 -: WORD_W];

  // one NIB_CNT-to-1 mux per output bit
  for (genvar b = 0; b < NIB_W; b++) begin : g_mux
    logic [NIB_CNT-1:0] bitSet;
    for (genvar n = 0; n < NIB_CNT; n++) begin : g_col
      assign bitSet[n] = outWord[n*NIB_W + b];
    end
    assign muxOut[b] = bitSet[hostSel];
  end

  assign hostNibbleOut = ctl.outHeld ? muxOut : '0;
endmodule

// File: rtl/nibble_link_bridge.sv
module nibble_link_bridge
  import nlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] hostNibbleIn,
  input  logic [SEL_W-1:0] hostSel,
  input  logic             hostWrStb,
  input  logic             hostRdStb,
  output logic [NIB_W-1:0] hostNibbleOut,
  output logic             hostCmdPending,
  output logic             hostRspAvail,
  output logic [CMD_W-1:0] cmdData,
  output logic             cmdValid,
  input  logic             cmdReady,
  input  logic [CMD_W-1:0] rspData,
  input  logic             rspValid,
  output logic             rspReady
);
  ctlStrobes_t ctl;
  logic        cmdPend;
  logic        rspHeld;

  nlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrStb(hostWrStb),
    .hostRdStb(hostRdStb), .cmdReady(cmdReady), .rspValid(rspValid),
    .cmdPend(cmdPend), .rspHeld(rspHeld), .ctl(ctl)
  );

  nlb_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostNibbleIn(hostNibbleIn),
    .hostSel(hostSel), .rspData(rspData), .cmdData(cmdData),
    .hostNibbleOut(hostNibbleOut)
  );

  assign cmdValid       = cmdPend;
  assign hostCmdPending = cmdPend;
  assign hostRspAvail   = rspHeld;
  assign rspReady       = !rspHeld;
endmodule

// File: rtl/nlb_checker.sv
module nlb_checker
  import nlb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] hostSel,
  input logic             hostWrStb,
  input logic             hostRdStb,
  input logic [NIB_W-1:0] hostNibbleOut,
  input logic             hostRspAvail,
  input logic [CMD_W-1:0] cmdData,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic             rspValid,
  input logic             rspReady
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NIB_CNT - 1);

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData)); // R4

  AST_CMD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(hostWrStb) && ($past(hostSel) == LAST)); // R4

  AST_RSP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady |=> hostRspAvail); // R6

  AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    hostRspAvail && !hostRdStb && !rspValid |=> $stable(hostSel) |-> $stable(hostNibbleOut)); // R7

  AST_OUT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hostRspAvail |-> hostNibbleOut == '0); // R7

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspReady) |-> $past(hostRdStb) && ($past(hostSel) == LAST)); // R8
endmodule

bind nibble_link_bridge nlb_checker u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrStb(hostWrStb),
  .hostRdStb(hostRdStb), .hostNibbleOut(hostNibbleOut),
  .hostRspAvail(hostRspAvail), .cmdData(cmdData), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .rspValid(rspValid), .rspReady(rspReady)
);

// File: tb/nibble_link_bridge_bench.sv
module nibble_link_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostNibbleIn = '0;
  logic [2:0]  hostSel = '0;
  logic        hostWrStb = 1'b0;
  logic        hostRdStb = 1'b0;
  logic [3:0]  hostNibbleOut;
  logic        hostCmdPending;
  logic        hostRspAvail;
  logic [55:0] cmdData;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [55:0] rspData = '0;
  logic        rspValid = 1'b0;
  logic        rspReady;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  nibble_link_bridge u_nibble_link_bridge (
    .clk(clk), .rstN(rstN), .hostNibbleIn(hostNibbleIn), .hostSel(hostSel),
    .hostWrStb(hostWrStb), .hostRdStb(hostRdStb), .hostNibbleOut(hostNibbleOut),
    .hostCmdPending(hostCmdPending), .hostRspAvail(hostRspAvail),
    .cmdData(cmdData), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .rspData(rspData), .rspValid(rspValid), .rspReady(rspReady)
  );

  // behavioural reference model
  int          mWrIdx, mRdIdx;
  bit          mWrHalf, mPend, mHeld, mRdHalf;
  logic [31:0] mWord, mHi;
  logic [55:0] mCmd, mRsp;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWrIdx = 0; mRdIdx = 0; mWrHalf = 0; mPend = 0; mHeld = 0; mRdHalf = 0;
      mWord = '0; mHi = '0; mCmd = '0; mRsp = '0;
    end else begin
      if (mPend) begin
        if (cmdReady) mPend = 0;
      end else if (hostWrStb && hostSel == mWrIdx) begin
        mWord[mWrIdx*4 +: 4] = hostNibbleIn;
        if (mWrIdx == 7) begin
          if (!mWrHalf) begin mHi = mWord; mWrHalf = 1; end
          else begin mCmd = {mHi, mWord[23:0]}; mPend = 1; mWrHalf = 0; end
        end
        mWrIdx = (mWrIdx + 1) % 8;
      end
      if (!mHeld) begin
        if (rspValid) begin mRsp = rspData; mHeld = 1; mRdIdx = 0; mRdHalf = 0; end
      end else if (hostRdStb && hostSel == mRdIdx) begin
        if (mRdIdx == 7) begin
          if (mRdHalf) mHeld = 0;
          mRdHalf = !mRdHalf;
        end
        mRdIdx = (mRdIdx + 1) % 8;
      end
    end
  end

  function automatic logic [3:0] expNib();
    logic [31:0] w;
    if (!mHeld) return 4'h0;
    w = mRdHalf ? {8'h00, mRsp[23:0]} : mRsp[55:24];
    return w[hostSel*4 +: 4];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      chk(cmdValid == mPend, "R4", "cmdValid", 64'(cmdValid), 64'(mPend));
      chk(hostCmdPending == mPend, "R5", "hostCmdPending", 64'(hostCmdPending), 64'(mPend));
      if (mPend) chk(cmdData == mCmd, "R3", "cmdData", 64'(cmdData), 64'(mCmd));
      chk(rspReady == !mHeld, "R6", "rspReady", 64'(rspReady), 64'(!mHeld));
      chk(hostRspAvail == mHeld, "R8", "hostRspAvail", 64'(hostRspAvail), 64'(mHeld));
      chk(hostNibbleOut == expNib(), "R7", "hostNibbleOut", 64'(hostNibbleOut), 64'(expNib()));
    end
  end

  task automatic wrNib(input logic [2:0] sel, input logic [3:0] nib);
    hostSel = sel; hostNibbleIn = nib; hostWrStb = 1'b1;
    @(negedge clk);
    hostWrStb = 1'b0;
  endtask

  task automatic sendHalf(input logic [31:0] w);
    for (int i = 0; i < 8; i++) wrNib(3'(i), w[i*4 +: 4]);
  endtask

  task automatic sendCmd(input logic [55:0] c, input logic [7:0] junk);
    sendHalf(c[55:24]);
    sendHalf({junk, c[23:0]});
  endtask

  task automatic readHalf(output logic [31:0] w);
    w = '0;
    for (int i = 0; i < 8; i++) begin
      hostSel = 3'(i); hostRdStb = 1'b1;
      #2 w[i*4 +: 4] = hostNibbleOut;
      @(negedge clk);
      hostRdStb = 1'b0;
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] h0, h1;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(!cmdValid && !hostCmdPending && !hostRspAvail && rspReady && hostNibbleOut == 0,
        "R1", "reset outputs", {59'd0, cmdValid, hostCmdPending, hostRspAvail, rspReady, 1'b0}, 64'h2);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R3 basic command, upper byte of second half ignored
    sendCmd(56'hA1B2C3D4E5F607, 8'hFF);
    #2 chk(cmdValid && cmdData == 56'hA1B2C3D4E5F607, "R3", "assembled command", 64'(cmdData), 64'hA1B2C3D4E5F607);
    // R5 writes refused while pending
    @(negedge clk);
    sendCmd(56'h11111111111111, 8'h00);
    #2 chk(cmdValid && cmdData == 56'hA1B2C3D4E5F607, "R5", "pending command kept", 64'(cmdData), 64'hA1B2C3D4E5F607);
    // R4 held until ready
    @(negedge clk); cmdReady = 1'b1;
    @(negedge clk); cmdReady = 1'b0;
    #2 chk(!cmdValid, "R4", "cmdValid after ready", 64'(cmdValid), 64'h0);
    @(negedge clk);

    // R2 out-of-order strobes ignored
    wrNib(3'd3, 4'hF);
    wrNib(3'd0, 4'h8);
    wrNib(3'd2, 4'hE);
    for (int i = 1; i < 8; i++) wrNib(3'(i), 4'(i + 8));
    sendHalf(32'h00765432);
    #2 chk(cmdValid && cmdData == 56'hFEDCBA98765432, "R2", "in-order slots only", 64'(cmdData), 64'hFEDCBA98765432);
    @(negedge clk); cmdReady = 1'b1;
    @(negedge clk); cmdReady = 1'b0;

    // R6, R7, R8 response readback
    rspData = 56'h0123456789ABCD; rspValid = 1'b1;
    @(negedge clk); rspValid = 1'b0; rspData = 56'hFFFFFFFFFFFFFF;
    #2 chk(hostRspAvail && !rspReady, "R6", "response captured", 64'(hostRspAvail), 64'h1);
    @(negedge clk);
    hostRdStb = 1'b1; hostSel = 3'd5;
    @(negedge clk); hostRdStb = 1'b0;
    readHalf(h0);
    chk(h0 == 32'h01234567, "R7", "first outbound half", 64'(h0), 64'h01234567);
    readHalf(h1);
    chk(h1 == 32'h0089ABCD, "R7", "second outbound half", 64'(h1), 64'h0089ABCD);
    #2 chk(rspReady && !hostRspAvail, "R8", "response released", 64'(rspReady), 64'h1);
    @(negedge clk);

    // back-to-back responses with a second pattern
    rspData = 56'hFEDCBA98765432; rspValid = 1'b1;
    @(negedge clk); rspValid = 1'b0;
    readHalf(h0);
    readHalf(h1);
    chk(h0 == 32'hFEDCBA98 && h1 == 32'h00765432, "R8", "second response halves",
        {h0, h1}, 64'hFEDCBA9800765432);

    // R9 reset mid-transfer
    sendHalf(32'h55555555);
    wrNib(3'd0, 4'h3); wrNib(3'd1, 4'h3); wrNib(3'd2, 4'h3);
    rspData = 56'h33333333333333; rspValid = 1'b1;
    @(negedge clk); rspValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    #2 chk(!hostRspAvail && hostNibbleOut == 0 && !cmdValid, "R9", "state after reset",
           64'(hostRspAvail), 64'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    sendCmd(56'h0F1E2D3C4B5A69, 8'h5A);
    #2 chk(cmdValid && cmdData == 56'h0F1E2D3C4B5A69, "R9", "command after reset", 64'(cmdData), 64'h0F1E2D3C4B5A69);
    @(negedge clk); cmdReady = 1'b1;
    @(negedge clk); cmdReady = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule